// File: doc/BRIEF.md
# Reset Source Sequencer

This block produces the system reset request for a chip and tells the boot logic which reset vector to use. It merges four sources into one request. The first is power-on, which holds reset for a fixed settle time after the power-good level rises. The second is an external active-low reset pin, which counts only after a minimum number of consecutive low cycles. The third is a computer-operating-properly watchdog that software must service. The fourth is a clock monitor that watches the system clock for activity.

The block runs on a free-running reference clock `clk`. The system clock arrives on `eclk_in` as a plain signal. The block synchronises it and detects its edges. Rising edges of the system clock drive the watchdog prescaler. Any edge of the system clock restarts the clock-monitor window. A watchdog or clock-monitor event cannot fire while a reset is in progress. Both of their counters restart from zero when the reset ends. The cause code keeps its last value after the reset is released, so the vector fetch can read it.

Top module: `sysrst_seq`

## Requirements
- R1: While `pwr_good` is sampled low, `rst_req` is 1 and `rst_cause` is 0 (power code) from the next cycle on.
- R2: After `pwr_good` rises, `rst_req` falls on the POR_CYCLES-th rising edge of `clk` at which `pwr_good` is sampled high.
- R3: A low on `rst_pin_n` lasting fewer than PIN_MIN consecutive cycles has no effect on `rst_req` or `rst_cause`.
- R4: A low on `rst_pin_n` lasting PIN_MIN or more consecutive cycles asserts `rst_req` with cause 0. The request stays high while the pin stays low, and for RST_HOLD cycles counted from the last low-sampled edge.
- R5: With `wd_en` high, the watchdog counts ticks. A tick is 2^PRE_W rising edges of the system clock, times a rate factor. When the WD_W-bit tick count rolls past all ones, `rst_req` is asserted for RST_HOLD cycles with cause 2.
- R6: `wd_rate` selects the rate factor: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R7: A one-cycle `wd_kick` clears the watchdog prescaler and count. With `wd_en` low the watchdog never raises a reset.
- R8: With `cm_en` high and no reset active, CM_WIN consecutive reference cycles with no system-clock edge assert `rst_req` for RST_HOLD cycles with cause 1. With `cm_en` low, a stopped clock raises no reset.
- R9: Watchdog and clock-monitor counters are held at zero during any reset. When events coincide, the cause follows the priority power/pin (0), then clock monitor (1), then watchdog (2). A pin event during another reset rewrites the cause to 0.
- R10: `rst_cause` does not change while `rst_req` stays low, and it is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| pwr_good | input | 1 | Supply-good level; low forces power reset and restarts the settle delay |
| rst_pin_n | input | 1 | External reset pin, active low, synchronous to `clk` |
| wd_en | input | 1 | Watchdog enable |
| wd_rate | input | 2 | Watchdog rate select (factor 1, 2, 4, 4) |
| wd_kick | input | 1 | Watchdog service strobe, one cycle |
| cm_en | input | 1 | Clock-monitor enable |
| eclk_in | input | 1 | System clock, asynchronous to `clk` |
| rst_req | output | 1 | System reset request |
| rst_cause | output | 2 | Vector cause: 0 power/pin, 1 clock monitor, 2 watchdog |

## Verification
The bench goes after the exact length of the settle delay and the pin qualifier. A design one cycle off in either would release reset early, or would accept a five-cycle glitch as a reset. It checks the watchdog rollover point and the rate factors. A wrong prescale limit or rate shift changes the reset interval, and a missing kick clear lets a serviced watchdog fire. It also checks that counters restart after every reset and that the cause priority holds. A monitor that keeps counting through the hold fires back-to-back, and a wrong priority reports the clock-monitor vector while a pin reset is in progress.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [1:0] {
        CAUSE_PWR    = 2'd0,
        CAUSE_CLKMON = 2'd1,
        CAUSE_WDOG   = 2'd2
    } cause_e;

    typedef struct packed {
        logic pin;
        logic clkmon;
        logic wdog;
    } fire_t;

    function automatic logic [1:0] rate_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    rate_shift = 2'd0;
            2'd1:    rate_shift = 2'd1;
            default: rate_shift = 2'd2;
        endcase
    endfunction

    function automatic cause_e pick_cause(input fire_t f, input cause_e prev);
        if (f.pin)         pick_cause = CAUSE_PWR;
        else if (f.clkmon) pick_cause = CAUSE_CLKMON;
        else if (f.wdog)   pick_cause = CAUSE_WDOG;
        else               pick_cause = prev;
    endfunction

    function automatic logic any_fire(input fire_t f);
        any_fire = f.pin | f.clkmon | f.wdog;
    endfunction

endpackage

// File: rtl/sysrst_eclk_edge.sv
module sysrst_eclk_edge (
    input  logic clk,
    input  logic pwr_good,
    input  logic eclk_in,
    output logic rise_o,
    output logic edge_o
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (!pwr_good) sh_q <= 3'b000;
        else           sh_q <= {sh_q[1:0], eclk_in};
    end

    assign rise_o = sh_q[1] & ~sh_q[2];
    assign edge_o = sh_q[1] ^ sh_q[2];
endmodule

// File: rtl/sysrst_settle.sv
module sysrst_settle #(
    parameter int POR_CYCLES = 4064
) (
    input  logic clk,
    input  logic pwr_good,
    output logic settling_o
);
    localparam int SW = $clog2(POR_CYCLES + 1);
    localparam logic [SW-1:0] DONE = SW'(POR_CYCLES);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!pwr_good)         cnt_q <= '0;
        else if (cnt_q != DONE) cnt_q <= cnt_q + SW'(1);
    end

    assign settling_o = (cnt_q != DONE);
endmodule

// File: rtl/sysrst_pin_qual.sv
module sysrst_pin_qual #(
    parameter int PIN_MIN = 6
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic rst_pin_n,
    output logic fire_o
);
    localparam int QW = (PIN_MIN > 2) ? $clog2(PIN_MIN) : 1;
    localparam logic [QW-1:0] LAST = QW'(PIN_MIN - 1);

    logic [QW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (!pwr_good || rst_pin_n) low_q <= '0;
        else if (low_q != LAST)     low_q <= low_q + QW'(1);
    end

    assign fire_o = pwr_good & ~rst_pin_n & (low_q == LAST);
endmodule

// File: rtl/sysrst_wdog.sv
module sysrst_wdog
    import sysrst_pkg::*;
#(
    parameter int PRE_W = 15,
    parameter int WD_W  = 16
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       en,
    input  logic [1:0] rate,
    input  logic       kick,
    input  logic       in_reset,
    input  logic       rise_i,
    output logic       fire_o
);
    localparam int PW = PRE_W + 2;

    logic [PW-1:0]   pre_q;
    logic [PW-1:0]   pre_last;
    logic [WD_W-1:0] wd_q;
    logic            clr;
    logic            tick;

    always_comb begin
        pre_last = (PW'(1) << (PRE_W + int'(rate_shift(rate)))) - PW'(1);
        clr      = ~pwr_good | ~en | kick | in_reset;
        tick     = rise_i & (pre_q >= pre_last);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            pre_q <= '0;
            wd_q  <= '0;
        end else if (rise_i) begin
            pre_q <= tick ? '0 : pre_q + PW'(1);
            if (tick) wd_q <= wd_q + WD_W'(1);
        end
    end

    assign fire_o = ~clr & tick & (&wd_q);
endmodule

// File: rtl/sysrst_clkmon.sv
module sysrst_clkmon #(
    parameter int CM_WIN = 64
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic en,
    input  logic in_reset,
    input  logic edge_i,
    output logic fire_o
);
    localparam int CW = (CM_WIN > 2) ? $clog2(CM_WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(CM_WIN - 1);

    logic [CW-1:0] idle_q;
    logic          clr;

    assign clr = ~pwr_good | ~en | in_reset | edge_i;

    always_ff @(posedge clk) begin
        if (clr)                 idle_q <= '0;
        else if (idle_q != LAST) idle_q <= idle_q + CW'(1);
    end

    assign fire_o = ~clr & (idle_q == LAST);
endmodule

// File: rtl/sysrst_seq.sv
module sysrst_seq
    import sysrst_pkg::*;
#(
    parameter int POR_CYCLES = 4064,
    parameter int PIN_MIN    = 6,
    parameter int PRE_W      = 15,
    parameter int WD_W       = 16,
    parameter int CM_WIN     = 64,
    parameter int RST_HOLD   = 16
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       rst_pin_n,
    input  logic       wd_en,
    input  logic [1:0] wd_rate,
    input  logic       wd_kick,
    input  logic       cm_en,
    input  logic       eclk_in,
    output logic       rst_req,
    output logic [1:0] rst_cause
);
    localparam int HW = $clog2(RST_HOLD + 1);

    logic          e_rise, e_edge;
    logic          settling;
    fire_t         fires;
    logic [HW-1:0] hold_q;
    cause_e        cause_q;

    sysrst_eclk_edge u_edge (
        .clk(clk), .pwr_good(pwr_good), .eclk_in(eclk_in),
        .rise_o(e_rise), .edge_o(e_edge)
    );

    sysrst_settle #(.POR_CYCLES(POR_CYCLES)) u_settle (
        .clk(clk), .pwr_good(pwr_good), .settling_o(settling)
    );

    sysrst_pin_qual #(.PIN_MIN(PIN_MIN)) u_pin (
        .clk(clk), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n),
        .fire_o(fires.pin)
    );

    sysrst_wdog #(.PRE_W(PRE_W), .WD_W(WD_W)) u_wdog (
        .clk(clk), .pwr_good(pwr_good), .en(wd_en), .rate(wd_rate),
        .kick(wd_kick), .in_reset(rst_req), .rise_i(e_rise),
        .fire_o(fires.wdog)
    );

    sysrst_clkmon #(.CM_WIN(CM_WIN)) u_cmon (
        .clk(clk), .pwr_good(pwr_good), .en(cm_en), .in_reset(rst_req),
        .edge_i(e_edge), .fire_o(fires.clkmon)
    );

    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            hold_q  <= '0;
            cause_q <= CAUSE_PWR;
        end else begin
            if (any_fire(fires))  hold_q <= HW'(RST_HOLD);
            else if (hold_q != '0) hold_q <= hold_q - HW'(1);
            cause_q <= pick_cause(fires, cause_q);
        end
    end

    assign rst_req   = settling | (hold_q != '0);
    assign rst_cause = cause_q;
endmodule

// File: rtl/sysrst_seq_chk.sv
module sysrst_seq_chk (
    input logic       clk,
    input logic       pwr_good,
    input logic       rst_pin_n,
    input logic       wd_en,
    input logic       cm_en,
    input logic       rst_req,
    input logic [1:0] rst_cause
);
    // R1
    pwr_low_chk: assert property (@(posedge clk)
        !pwr_good |=> (rst_req && rst_cause == 2'd0));

    // R4
    pin_src_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ($rose(rst_req) && $past(pwr_good) && rst_cause == 2'd0) |-> !$past(rst_pin_n));

    // R5
    wd_src_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ($rose(rst_req) && rst_cause == 2'd2) |-> $past(wd_en));

    // R8
    cm_src_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ($rose(rst_req) && rst_cause == 2'd1) |-> $past(cm_en));

    // R10
    cause_keep_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (!rst_req && $past(pwr_good)) |-> $stable(rst_cause));

    // R10
    cause_code_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        rst_cause != 2'd3);
endmodule

bind sysrst_seq sysrst_seq_chk u_chk (
    .clk(clk), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n), .wd_en(wd_en),
    .cm_en(cm_en), .rst_req(rst_req), .rst_cause(rst_cause)
);

// File: tb/sim_sysrst_seq.sv
module sim_sysrst_seq;
    localparam int POR  = 100;
    localparam int PMIN = 6;
    localparam int PREW = 2;
    localparam int WDW  = 4;
    localparam int CMW  = 20;
    localparam int HOLD = 8;

    logic clk = 0;
    logic pg = 0, pin_n = 1, wd_en = 0, kick = 0, cm_en = 0, eclk = 0;
    logic [1:0] rate = 0;
    logic rst_req;
    logic [1:0] cause;
    bit eclk_run = 1;
    int ediv = 0;
    int checks = 0, fails = 0;
    bit cmp_on = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    sysrst_seq #(.POR_CYCLES(POR), .PIN_MIN(PMIN), .PRE_W(PREW), .WD_W(WDW),
                 .CM_WIN(CMW), .RST_HOLD(HOLD)) u0 (
        .clk(clk), .pwr_good(pg), .rst_pin_n(pin_n), .wd_en(wd_en),
        .wd_rate(rate), .wd_kick(kick), .cm_en(cm_en), .eclk_in(eclk),
        .rst_req(rst_req), .rst_cause(cause));

    always @(negedge clk) begin
        #1;
        if (eclk_run) begin
            ediv++;
            if (ediv == 2) begin eclk = ~eclk; ediv = 0; end
        end
    end

    // behavioural reference: per-edge update of delays, counts and cause
    int q[$] = '{0, 0, 0};
    int m_por = 0, m_low = 0, m_pre = 0, m_wd = 0, m_idle = 0, m_hold = 0, m_cause = 0;

    function automatic bit model_rst();
        return (m_por < POR) || (m_hold > 0);
    endfunction

    always @(posedge clk) begin
        bit in_rst, rise, edg, pf, wf, cf, tick, wclr, cclr;
        int lim;
        in_rst = model_rst();
        rise = (q[1] == 1) && (q[2] == 0);
        edg  = (q[1] != q[2]);
        pf = pg && !pin_n && (m_low >= PMIN - 1);
        lim = (2 ** PREW) * ((rate == 0) ? 1 : (rate == 1) ? 2 : 4);
        tick = rise && (m_pre + 1 >= lim);
        wclr = !pg || !wd_en || kick || in_rst;
        wf = !wclr && tick && (m_wd == 2 ** WDW - 1);
        cclr = !pg || !cm_en || in_rst || edg;
        cf = !cclr && (m_idle >= CMW - 1);
        if (!pg) begin
            m_por = 0; m_low = 0; m_hold = 0; m_cause = 0;
            q = '{0, 0, 0};
        end else begin
            if (m_por < POR) m_por++;
            m_low = pin_n ? 0 : m_low + 1;
            if (pf || wf || cf) m_hold = HOLD;
            else if (m_hold > 0) m_hold--;
            if (pf) m_cause = 0;
            else if (cf) m_cause = 1;
            else if (wf) m_cause = 2;
            q.push_front(int'(eclk)); void'(q.pop_back());
        end
        if (wclr) begin m_pre = 0; m_wd = 0; end
        else if (rise) begin
            if (tick) begin m_pre = 0; m_wd = (m_wd + 1) % (2 ** WDW); end
            else m_pre++;
        end
        if (cclr) m_idle = 0; else m_idle++;
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (cmp_on) begin
        chk(rst_req == model_rst(), {phase, " rst_req"}, int'(rst_req), int'(model_rst()));
        chk(int'(cause) == m_cause, {phase, " cause"}, int'(cause), m_cause);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wait_rst(int limit, output int n);
        n = 0;
        while (rst_req == 0 && n < limit) begin @(negedge clk); n++; end
        #2;
    endtask

    task automatic high_len(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (rst_req) n++; else break;
        end
        #2;
    endtask

    task automatic count_hi(int cycles, output int n);
        n = 0;
        repeat (cycles) begin @(negedge clk); if (rst_req) n++; end
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, n0, n0b, n1;
        cyc(4);
        cmp_on = 1;
        chk(rst_req == 1, "R1 reset req", int'(rst_req), 1);
        chk(cause == 0, "R1 reset cause", int'(cause), 0);

        phase = "R2"; pg = 1;
        high_len(n);
        chk(n == POR - 1, "R2 settle length", n, POR - 1);

        phase = "R3"; pin_n = 0; cyc(PMIN - 1); pin_n = 1;
        count_hi(20, n);
        chk(n == 0, "R3 short pin pulse", n, 0);

        phase = "R4"; pin_n = 0; cyc(PMIN + 4);
        chk(rst_req == 1, "R4 pin reset", int'(rst_req), 1);
        chk(cause == 0, "R4 pin cause", int'(cause), 0);
        pin_n = 1;
        high_len(n);
        chk(n == HOLD - 1, "R4 hold after release", n, HOLD - 1);

        phase = "R5"; wd_en = 1; rate = 0;
        wait_rst(3000, n);
        chk(rst_req == 1, "R5 watchdog fired", int'(rst_req), 1);
        chk(cause == 2, "R5 watchdog cause", int'(cause), 2);
        high_len(n);
        chk(n == HOLD - 1, "R5 hold length", n, HOLD - 1);

        phase = "R9";
        wait_rst(3000, n0); high_len(n);
        wait_rst(3000, n0b); high_len(n);
        chk(n0 - n0b <= 4 && n0b - n0 <= 4, "R9 watchdog restarts after reset", n0b, n0);

        phase = "R6"; rate = 1;
        wait_rst(3000, n); high_len(n);
        wait_rst(3000, n1); high_len(n);
        chk(n1 > n0 + 200 && n1 < 2 * n0 + 40, "R6 rate factor 2", n1, 2 * n0);

        phase = "R10"; wd_en = 0;
        cyc(50);
        chk(cause == 2, "R10 cause kept", int'(cause), 2);
        chk(rst_req == 0, "R10 no request", int'(rst_req), 0);

        phase = "R7"; wd_en = 1; rate = 0;
        n1 = 0;
        for (int i = 0; i < 15; i++) begin
            count_hi(99, n); n1 += n;
            kick = 1; cyc(1); kick = 0;
        end
        chk(n1 == 0, "R7 kicked watchdog silent", n1, 0);
        wd_en = 0;
        count_hi(1500, n);
        chk(n == 0, "R7 disabled watchdog silent", n, 0);

        phase = "R8"; cm_en = 1;
        count_hi(400, n);
        chk(n == 0, "R8 running clock no reset", n, 0);
        eclk_run = 0;
        wait_rst(200, n);
        chk(rst_req == 1, "R8 stopped clock reset", int'(rst_req), 1);
        chk(cause == 1, "R8 clock monitor cause", int'(cause), 1);

        phase = "R9"; pin_n = 0; cyc(PMIN + 2);
        chk(cause == 0, "R9 pin overrides clock monitor", int'(cause), 0);
        pin_n = 1; cm_en = 0;
        high_len(n);
        count_hi(300, n);
        chk(n == 0, "R8 monitor disabled no reset", n, 0);
        eclk_run = 1;

        phase = "R1"; pg = 0; cyc(3);
        chk(rst_req == 1 && cause == 0, "R1 supply drop", int'(rst_req), 1);
        pg = 1; cyc(POR + 5);
        chk(rst_req == 0, "R2 second settle done", int'(rst_req), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule